// File: doc/BRIEF.md
# Burst-Gated Slave FIFO Writer

This block sits between a stream of 32-bit sample words and the synchronous slave-FIFO write port of an external USB bridge. Samples arrive at an irregular, often low, rate and are held in an internal buffer FIFO. The writer does not trickle words out. It waits until a full burst of 256 words (1 KB) is queued and then writes that burst in back-to-back clock cycles. Between bursts the write strobe goes high while chip select stays low.

Bursts are counted. Sixteen bursts fill one 16 KB bridge buffer. The word that closes a buffer carries a packet-end strobe. The writer then lets the bridge's per-thread ready flag settle for a fixed number of cycles before it samples the flag again. In two-thread mode it alternates between thread 0 and thread 1 after every buffer. The final word of the whole transfer also carries packet-end, and a one-cycle done pulse comes with it. If a sample arrives while the internal FIFO is full, a sticky overflow flag is raised.

All bridge-facing outputs are registered. Data, address, write strobe and packet-end therefore change on the same clock edge.

Top module: `burst_fifo_writer`

## Requirements
- R1: A write run begins only when the FIFO holds at least N words, where N is the lesser of the burst size and the words still to send. Each run is exactly N words written on consecutive cycles.
- R2: Words appear on `if_data` in the order they were accepted on `in_data`, and only while `if_wr_n` is low.
- R3: `if_cs_n` is low and `busy` is high from the cycle after an accepted start up to and including the cycle of the final write. This includes the idle gaps between bursts. Both return to idle in the next cycle.
- R4: `if_pktend_n` is low together with the last word of every full buffer of BURST_WORDS*BURSTS_PER_BUF words, and it is never low without a write.
- R5: The final word of the transfer carries `if_pktend_n` low, even when it does not end a buffer. `done` is high for exactly that one cycle.
- R6: In two-thread mode, `if_addr` is 0 for words in even-numbered buffers and 1 for words in odd-numbered buffers, counting from 0 at start. The address holds steady within a buffer.
- R7: After a buffer-closing word (not the final word), the bus stays idle for at least SETTLE_CYC+2 cycles before the next write.
- R8: Writing to a thread begins or resumes only after that thread's ready flag has been sampled high after the settling delay: `flag_a` for thread 0, `flag_b` for thread 1. While the flag stays low, no word is written.
- R9: A sample presented while the FIFO holds FIFO_DEPTH words sets `overflow` one cycle later. `overflow` then stays high until reset.
- R10: `start` is ignored while `busy` is high and when `xfer_len` is zero. The length loaded at an accepted start governs the whole transfer.
- R11: After reset: `if_wr_n`, `if_pktend_n` and `if_cs_n` are high; `busy`, `done` and `overflow` are low; `if_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock, also driven to the bridge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample word present on `in_data` |
| in_data | input | DATA_W | Sample word |
| start | input | 1 | Begin a transfer of `xfer_len` words |
| xfer_len | input | LEN_W | Transfer length in words, loaded at start |
| flag_a | input | 1 | Thread 0 has a free buffer |
| flag_b | input | 1 | Thread 1 has a free buffer |
| if_data | output | DATA_W | Bridge data bus |
| if_addr | output | 2 | Bridge thread address |
| if_cs_n | output | 1 | Chip select, active low |
| if_wr_n | output | 1 | Write strobe, active low |
| if_pktend_n | output | 1 | Packet-end strobe, active low |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse with the final word |
| overflow | output | 1 | Sticky FIFO overflow error |

## Verification
The hardest case to reach is a ready flag that is still high just after a buffer closes and drops only a couple of cycles later. This is how a bridge behaves while it updates its flag, and a writer that samples the flag too early would write into a buffer that is not there. The bench waits for the first buffer-closing packet-end and lowers the next thread's flag two edges later, before the settling window ends. It holds the flag low for tens of cycles and confirms that no word leaves, then raises the flag and checks that the rest of the stream follows. The overflow case is reached by keeping both flags low so that nothing drains, then feeding one word more than the FIFO depth.

// File: rtl/bfw_pkg.sv
package bfw_pkg;
  localparam int unsigned THREAD_ADDR_W = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_FLAG,
    ST_WAIT_FILL,
    ST_BURST,
    ST_SETTLE
  } bfw_state_e;
endpackage

// File: rtl/bfw_sample_fifo.sv
module bfw_sample_fifo #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 1024,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_valid,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] pop_data,
  output logic [CNT_W-1:0]  level,
  output logic              dropped
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0]  level_q;
  logic              full, do_push;

  assign full    = (level_q == CNT_W'(DEPTH));
  assign do_push = push_valid && !full;
  assign dropped = push_valid && full;
  assign level   = level_q;

  // storage and read register kept reset-free so a block RAM can hold them
  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr_q] <= push_data;
    if (pop)     pop_data      <= mem[rd_ptr_q];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      level_q  <= '0;
    end else begin
      if (do_push) wr_ptr_q <= wr_ptr_q + 1'b1;
      if (pop)     rd_ptr_q <= rd_ptr_q + 1'b1;
      case ({do_push, pop})
        2'b10:   level_q <= level_q + 1'b1;
        2'b01:   level_q <= level_q - 1'b1;
        default: level_q <= level_q;
      endcase
    end
  end
endmodule

// File: rtl/bfw_write_ctrl.sv
module bfw_write_ctrl
  import bfw_pkg::*;
#(
  parameter int unsigned LEN_W          = 32,
  parameter int unsigned CNT_W          = 11,
  parameter int unsigned BURST_WORDS    = 256,
  parameter int unsigned BURSTS_PER_BUF = 16,
  parameter int unsigned SETTLE_CYC     = 4,
  parameter bit          TWO_THREAD     = 1'b1,
  localparam int unsigned BCNT_W = $clog2(BURST_WORDS + 1),
  localparam int unsigned BIDX_W = $clog2(BURSTS_PER_BUF + 1),
  localparam int unsigned SET_W  = $clog2(SETTLE_CYC + 1)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start,
  input  logic [LEN_W-1:0]         xfer_len,
  input  logic [CNT_W-1:0]         level,
  input  logic                     flag_a,
  input  logic                     flag_b,
  output logic                     pop,
  output logic                     wr_n,
  output logic                     pktend_n,
  output logic                     cs_n,
  output logic [THREAD_ADDR_W-1:0] addr,
  output logic                     done
);
  bfw_state_e        state_q;
  logic [LEN_W-1:0]  remaining_q;
  logic [BCNT_W-1:0] burst_left_q;
  logic [BIDX_W-1:0] bursts_q;
  logic [SET_W-1:0]  settle_q;
  logic              thread_q, next_thread, sel_flag;
  logic [LEN_W-1:0]  need;
  logic              fill_ok, start_ok, last_word, last_burst, buf_full;

  // thread selection variant
  generate
    if (TWO_THREAD) begin : g_two
      assign next_thread = ~thread_q;
      assign sel_flag    = thread_q ? flag_b : flag_a;
    end else begin : g_one
      assign next_thread = 1'b0;
      assign sel_flag    = flag_a;
    end
  endgenerate

  assign need       = (remaining_q < LEN_W'(BURST_WORDS)) ? remaining_q : LEN_W'(BURST_WORDS);
  assign fill_ok    = (LEN_W'(level) >= need);
  assign start_ok   = start && (state_q == ST_IDLE) && cs_n && (xfer_len != '0);
  assign pop        = (state_q == ST_BURST);
  assign last_word  = (remaining_q == LEN_W'(1));
  assign last_burst = (burst_left_q == BCNT_W'(1));
  assign buf_full   = last_burst && (bursts_q == BIDX_W'(BURSTS_PER_BUF - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_IDLE;
      remaining_q  <= '0;
      burst_left_q <= '0;
      bursts_q     <= '0;
      settle_q     <= '0;
      thread_q     <= 1'b0;
      wr_n         <= 1'b1;
      pktend_n     <= 1'b1;
      cs_n         <= 1'b1;
      addr         <= '0;
      done         <= 1'b0;
    end else begin
      wr_n     <= !pop;
      pktend_n <= !(pop && (last_word || buf_full));
      done     <= pop && last_word;
      cs_n     <= !(start_ok || (state_q != ST_IDLE));
      if (pop) addr <= THREAD_ADDR_W'(thread_q);

      case (state_q)
        ST_IDLE: begin
          if (start_ok) begin
            remaining_q <= xfer_len;
            thread_q    <= 1'b0;
            bursts_q    <= '0;
            state_q     <= ST_WAIT_FLAG;
          end
        end
        ST_WAIT_FLAG: begin
          if (sel_flag) state_q <= ST_WAIT_FILL;
        end
        ST_WAIT_FILL: begin
          if (fill_ok) begin
            burst_left_q <= need[BCNT_W-1:0];
            state_q      <= ST_BURST;
          end
        end
        ST_BURST: begin
          remaining_q  <= remaining_q - 1'b1;
          burst_left_q <= burst_left_q - 1'b1;
          if (last_word) begin
            state_q <= ST_IDLE;
          end else if (buf_full) begin
            bursts_q <= '0;
            thread_q <= next_thread;
            settle_q <= '0;
            state_q  <= ST_SETTLE;
          end else if (last_burst) begin
            bursts_q <= bursts_q + 1'b1;
            state_q  <= ST_WAIT_FILL;
          end
        end
        ST_SETTLE: begin
          if (settle_q == SET_W'(SETTLE_CYC - 1)) state_q <= ST_WAIT_FLAG;
          else settle_q <= settle_q + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/burst_fifo_writer.sv
module burst_fifo_writer
  import bfw_pkg::*;
#(
  parameter int unsigned DATA_W         = 32,
  parameter int unsigned FIFO_DEPTH     = 1024,
  parameter int unsigned BURST_WORDS    = 256,
  parameter int unsigned BURSTS_PER_BUF = 16,
  parameter int unsigned SETTLE_CYC     = 4,
  parameter int unsigned LEN_W          = 32,
  parameter bit          TWO_THREAD     = 1'b1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic [DATA_W-1:0]        in_data,
  input  logic                     start,
  input  logic [LEN_W-1:0]         xfer_len,
  input  logic                     flag_a,
  input  logic                     flag_b,
  output logic [DATA_W-1:0]        if_data,
  output logic [THREAD_ADDR_W-1:0] if_addr,
  output logic                     if_cs_n,
  output logic                     if_wr_n,
  output logic                     if_pktend_n,
  output logic                     busy,
  output logic                     done,
  output logic                     overflow
);
  localparam int unsigned CNT_W = $clog2(FIFO_DEPTH + 1);

  logic [CNT_W-1:0] level;
  logic             pop, dropped, overflow_q;

  bfw_sample_fifo #(
    .DATA_W (DATA_W),
    .DEPTH  (FIFO_DEPTH)
  ) u_fifo (
    .clk        (clk),
    .rst        (rst),
    .push_valid (in_valid),
    .push_data  (in_data),
    .pop        (pop),
    .pop_data   (if_data),
    .level      (level),
    .dropped    (dropped)
  );

  bfw_write_ctrl #(
    .LEN_W          (LEN_W),
    .CNT_W          (CNT_W),
    .BURST_WORDS    (BURST_WORDS),
    .BURSTS_PER_BUF (BURSTS_PER_BUF),
    .SETTLE_CYC     (SETTLE_CYC),
    .TWO_THREAD     (TWO_THREAD)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .xfer_len (xfer_len),
    .level    (level),
    .flag_a   (flag_a),
    .flag_b   (flag_b),
    .pop      (pop),
    .wr_n     (if_wr_n),
    .pktend_n (if_pktend_n),
    .cs_n     (if_cs_n),
    .addr     (if_addr),
    .done     (done)
  );

  always_ff @(posedge clk) begin
    if (rst)          overflow_q <= 1'b0;
    else if (dropped) overflow_q <= 1'b1;
  end

  assign overflow = overflow_q;
  assign busy     = !if_cs_n;
endmodule

// File: rtl/bfw_checker.sv
module bfw_checker (
  input logic       clk,
  input logic       rst,
  input logic [1:0] if_addr,
  input logic       if_cs_n,
  input logic       if_wr_n,
  input logic       if_pktend_n,
  input logic       done,
  input logic       overflow
);
  p_wr_selected_r3: assert property (@(posedge clk) disable iff (rst)
    !if_wr_n |-> !if_cs_n);

  p_pktend_with_word_r4: assert property (@(posedge clk) disable iff (rst)
    !if_pktend_n |-> !if_wr_n);

  p_done_final_word_r5: assert property (@(posedge clk) disable iff (rst)
    done |-> (!if_pktend_n && !if_wr_n));

  p_idle_after_done_r5: assert property (@(posedge clk) disable iff (rst)
    done |=> (if_wr_n && if_cs_n));

  p_addr_steady_r6: assert property (@(posedge clk) disable iff (rst)
    (!if_wr_n && $past(!if_wr_n) && $past(if_pktend_n)) |-> $stable(if_addr));

  p_settle_gap_r7: assert property (@(posedge clk) disable iff (rst)
    (!if_pktend_n && !done) |=> if_wr_n ##1 if_wr_n);

  p_overflow_held_r9: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);
endmodule

bind burst_fifo_writer bfw_checker u_chk (
  .clk         (clk),
  .rst         (rst),
  .if_addr     (if_addr),
  .if_cs_n     (if_cs_n),
  .if_wr_n     (if_wr_n),
  .if_pktend_n (if_pktend_n),
  .done        (done),
  .overflow    (overflow)
);

// File: tb/burst_fifo_writer_tb.sv
`timescale 1ns/1ps
module burst_fifo_writer_tb;
  localparam int DW = 32, DEPTH = 32, BURST = 8, BPB = 4, SETTLE = 4, LW = 16;
  localparam int BUFW = BURST * BPB;

  logic clk = 1'b0, rst = 1'b1;
  logic in_valid = 1'b0, start = 1'b0, flag_a = 1'b1, flag_b = 1'b1;
  logic [DW-1:0] in_data = '0;
  logic [LW-1:0] xfer_len = '0;
  logic [DW-1:0] if_data;
  logic [1:0] if_addr;
  logic if_cs_n, if_wr_n, if_pktend_n, busy, done, overflow;

  burst_fifo_writer #(
    .DATA_W(DW), .FIFO_DEPTH(DEPTH), .BURST_WORDS(BURST), .BURSTS_PER_BUF(BPB),
    .SETTLE_CYC(SETTLE), .LEN_W(LW), .TWO_THREAD(1'b1)
  ) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .start(start),
    .xfer_len(xfer_len), .flag_a(flag_a), .flag_b(flag_b), .if_data(if_data),
    .if_addr(if_addr), .if_cs_n(if_cs_n), .if_wr_n(if_wr_n), .if_pktend_n(if_pktend_n),
    .busy(busy), .done(done), .overflow(overflow)
  );

  always #4 clk = ~clk;

  int n_checks = 0, n_fail = 0, cyc = 0;
  logic [DW-1:0] exp_q[$];
  logic [DW-1:0] next_word = 32'h1234_5678;
  int len_m = 0, wr_m = 0, wr_tot = 0, pushes = 0, ph1 = 0, ph2 = 0, ph3 = 0;
  int run_len = 0, need_m = 0, gap = 0, bufend_cnt = 0, done_cnt = 0;
  int feed_left = 0, feed_period = 1;
  bit busy_m = 0, ovf_m = 0, prev_low = 0, after_buf = 0, end_pend = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic do_start(input int len);
    start = 1'b1; xfer_len = LW'(len);
    tick(1);
    start = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    exp_q.delete();
    pushes = 0; wr_tot = 0; wr_m = 0; ph1 = 0; ph2 = 0; ph3 = 0;
    busy_m = 0; ovf_m = 0; prev_low = 0; after_buf = 0; end_pend = 0; feed_left = 0;
    tick(4);
    rst = 1'b0;
  endtask

  // reference model, compared on every clock at the falling edge
  always @(negedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_fail++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 20000);
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
    if (rst) begin
      in_valid = 1'b0;
    end else begin
      if (!if_wr_n) begin
        if (!prev_low) begin
          need_m = (len_m - wr_m < BURST) ? len_m - wr_m : BURST;
          chk(ph3 - wr_tot >= need_m, "R1 fill level at burst start", ph3 - wr_tot, need_m);
          if (after_buf) chk(gap >= SETTLE + 2, "R7 settle gap", gap, SETTLE + 2);
          after_buf = 0;
          run_len = 0;
        end
        run_len++;
        if (exp_q.size() == 0) chk(0, "R2 write with no sample", 1, 0);
        else begin
          logic [DW-1:0] e;
          e = exp_q.pop_front();
          chk(if_data == e, "R2 data order", if_data, e);
        end
        begin
          bit last, bend;
          last = (wr_m == len_m - 1);
          bend = ((wr_m % BUFW) == BUFW - 1);
          chk(if_pktend_n == !(last || bend), last ? "R5 pktend on final word" : "R4 pktend at buffer end",
              if_pktend_n, !(last || bend));
          chk(done == last, "R5 done pulse", done, last);
          chk(if_addr == 2'((wr_m / BUFW) % 2), "R6 thread address", if_addr, (wr_m / BUFW) % 2);
          wr_m++; wr_tot++;
          if (last) begin end_pend = 1; done_cnt++; end
          else if (bend) begin after_buf = 1; gap = 0; bufend_cnt++; end
        end
        prev_low = 1;
      end else begin
        if (prev_low) chk(run_len == need_m, "R1 burst length", run_len, need_m);
        chk(if_pktend_n && !done, "R4 strobes idle without write", {if_pktend_n, done}, 2);
        gap++;
        prev_low = 0;
      end
      chk(busy == busy_m, "R3 busy", busy, busy_m);
      chk(if_cs_n == !busy_m, "R3 chip select", if_cs_n, !busy_m);
      chk(overflow == ovf_m, "R9 overflow", overflow, ovf_m);
      if (start && !busy_m && xfer_len != 0) begin
        busy_m = 1; len_m = int'(xfer_len); wr_m = 0;
      end
      if (end_pend) begin busy_m = 0; end_pend = 0; end
      if (feed_left > 0 && (cyc % feed_period) == 0) begin
        in_valid = 1'b1; in_data = next_word;
        if (pushes - wr_tot >= DEPTH) ovf_m = 1;
        else begin exp_q.push_back(next_word); pushes++; end
        next_word = next_word * 32'h0019_660D + 32'h3C6E_F35F;
        feed_left--;
      end else in_valid = 1'b0;
      ph3 = ph2; ph2 = ph1; ph1 = pushes;
    end
  end

  initial begin
    int w0;
    do_reset();
    // R11 reset state
    chk(if_wr_n && if_pktend_n && if_cs_n, "R11 strobes high after reset", {if_wr_n, if_pktend_n, if_cs_n}, 7);
    chk(!busy && !done && !overflow, "R11 status low after reset", {busy, done, overflow}, 0);
    chk(if_addr == 2'd0, "R11 address zero after reset", if_addr, 0);

    // low-rate stream, length not a multiple of a burst, restart attempt mid-transfer
    feed_period = 3; feed_left = 100;
    do_start(100);
    wait (wr_m >= 20);
    tick(1);
    do_start(7);
    wait (busy_m == 0);
    tick(3);
    chk(wr_m == 100, "R10 start ignored while busy", wr_m, 100);
    chk(done_cnt == 1, "R5 single done pulse", done_cnt, 1);

    // R10 zero length ignored
    do_start(0);
    tick(3);
    chk(!busy && if_cs_n, "R10 zero length ignored", busy, 0);

    // R8 stale flag: next thread flag drops inside the settling window
    feed_period = 2; feed_left = 64;
    w0 = bufend_cnt;
    do_start(64);
    wait (bufend_cnt == w0 + 1);
    tick(2);
    flag_b = 1'b0;
    w0 = wr_m;
    tick(40);
    chk(w0 == BUFW, "R8 first buffer complete before stall", w0, BUFW);
    chk(wr_m == w0, "R8 no write while flag low", wr_m, w0);
    flag_b = 1'b1;
    wait (busy_m == 0);
    tick(3);
    chk(wr_m == 64, "R8 stream resumes after flag", wr_m, 64);

    // R9 overflow with nothing draining
    do_reset();
    flag_a = 1'b0; flag_b = 1'b0;
    do_start(100);
    feed_period = 1; feed_left = DEPTH;
    wait (feed_left == 0);
    tick(3);
    chk(overflow == 1'b0, "R9 full FIFO without extra word", overflow, 0);
    feed_left = 1;
    wait (feed_left == 0);
    tick(3);
    chk(overflow == 1'b1, "R9 overflow set", overflow, 1);
    tick(6);
    chk(overflow == 1'b1, "R9 overflow held", overflow, 1);

    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule